// File: doc/BRIEF.md
# Flash Array Control Registers with Write Lock

This block holds the control fields for a flash array controller: three 8-bit protection-related fields (supervisor-only marking, data-space marking and program/erase protection), a lock flag that freezes those fields once set, and a disable flag that stops the array from answering accesses. Software reaches the fields through a small 32-bit register bus. Each access completes one cycle after its request.

The lock flag is meant to be set once, after start-up configuration. From then on, writes to the three fields are dropped quietly while the bus cycle still completes. Only a master reset clears the flag, unless the debug-mode input is high. The disable flag takes its reset value from a configuration pin. While a program or erase session is running, writes to it are dropped. When it is set, array accesses get no acknowledge. Instead they end with a no-response pulse after a fixed timeout.

Top module: `flash_reg_lock`

## Requirements
- R1: On a clock edge with `rst_n` low, `lock` becomes 0, `supv`, `dspace` and `protect` become 0xFF, `arr_disable` takes the value of `cfg_disable`, and `reg_done`, `arr_ack` and `arr_noresp` become 0.
- R2: With `debug_mode` low, a write to offset 0x0 with bit 31 set makes `lock` 1. Once `lock` is 1, a write with bit 31 clear leaves it at 1 until the next reset.
- R3: With `debug_mode` high, `lock` takes bit 31 of every write to offset 0x0, so it can be cleared as well as set.
- R4: While `lock` is 1 before a write, the write leaves `supv` (offset 0x0 bits 15:8), `dspace` (offset 0x4 bits 7:0) and `protect` (offset 0x4 bits 15:8) unchanged. Every register access, read or write, raises `reg_done` for exactly the one cycle after its request.
- R5: A write that finds `lock` at 0 updates the protected fields it addresses, even when the same write sets `lock`.
- R6: A write to offset 0x0 copies bit 30 into `arr_disable` only while `session_active` is low. While `session_active` is high, `arr_disable` is left unchanged.
- R7: An `arr_req` pulse that arrives while `arr_disable` is 0 and no access is pending raises `arr_ack` for the following cycle.
- R8: An `arr_req` pulse that arrives while `arr_disable` is 1 never raises `arr_ack`. It raises `arr_noresp` for one cycle, starting TIMEOUT (4) clock edges after the request edge. Array requests that arrive during that wait are ignored.
- R9: A read returns `{lock, arr_disable, 14'b0, supv, 8'b0}` at offset 0x0 and `{16'b0, protect, dspace}` at offset 0x4, in the cycle of `reg_done`. Any other offset reads 0 and ignores writes. `reg_rdata` is 0 when no read is completing. `lock` and `arr_disable` read back regardless of the lock state.
- R10: `arr_enable` is the inverse of `arr_disable` at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Master reset, active low, synchronous |
| cfg_disable | input | 1 | Configuration pin sampled into the disable flag during reset |
| debug_mode | input | 1 | Debug mode; makes the lock flag freely writable |
| session_active | input | 1 | Program/erase session in progress; blocks disable-flag writes |
| reg_req | input | 1 | Register access request, one cycle per access |
| reg_we | input | 1 | 1 for write, 0 for read |
| reg_addr | input | 4 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_done |
| reg_done | output | 1 | Access complete, one cycle after reg_req |
| arr_req | input | 1 | Array access request pulse |
| arr_ack | output | 1 | Array access acknowledged |
| arr_noresp | output | 1 | Array access ended without response after timeout |
| arr_enable | output | 1 | Array accesses are being answered |
| arr_disable | output | 1 | Disable flag |
| lock | output | 1 | Lock flag |
| supv | output | 8 | Supervisor-only field |
| dspace | output | 8 | Data-space field |
| protect | output | 8 | Program/erase protect field |

## Verification
Every output of this block is a register. A register write shows up on the field outputs and `reg_done` one edge after the request edge, and a read shows up on `reg_rdata` one edge after it. An enabled array access is acknowledged one edge after the request, and a disabled one reports its timeout four edges after the request. The only exception is `arr_enable`, which follows `arr_disable` in the same cycle. The bench keeps a behavioural model that it updates on every rising edge from the stimulus it applied. It compares all outputs against that model at the falling edge that follows, so each result is checked in exactly the cycle it is due. Separate spot checks cover the reset values, the debug-mode unlock and the write that locks and updates in the same cycle.

// File: rtl/flash_reg_lock.sv
module flash_reg_lock #(
  parameter int FW      = 8,
  parameter int AW      = 4,
  parameter int TIMEOUT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_disable,
  input  logic          debug_mode,
  input  logic          session_active,
  input  logic          reg_req,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          reg_done,
  input  logic          arr_req,
  output logic          arr_ack,
  output logic          arr_noresp,
  output logic          arr_enable,
  output logic          arr_disable,
  output logic          lock,
  output logic [FW-1:0] supv,
  output logic [FW-1:0] dspace,
  output logic [FW-1:0] protect
);
  localparam logic [AW-1:0] OFS_CTRL  = AW'(0);
  localparam logic [AW-1:0] OFS_SPACE = AW'(4);
  localparam int CW = $clog2(TIMEOUT + 1);
  localparam logic [FW-1:0] FIELD_RST = {FW{1'b1}};

  logic          wr_ctrl, wr_space, rd;
  logic          busy;
  logic [CW-1:0] cnt;
  logic [31:0]   rd_mux;

  assign wr_ctrl  = reg_req && reg_we && (reg_addr == OFS_CTRL);
  assign wr_space = reg_req && reg_we && (reg_addr == OFS_SPACE);
  assign rd       = reg_req && !reg_we;
  assign arr_enable = !arr_disable;

  always_comb begin
    rd_mux = '0;
    if (reg_addr == OFS_CTRL) begin
      rd_mux[31]        = lock;
      rd_mux[30]        = arr_disable;
      rd_mux[8 +: FW]   = supv;
    end else if (reg_addr == OFS_SPACE) begin
      rd_mux[0 +: FW]   = dspace;
      rd_mux[8 +: FW]   = protect;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock        <= 1'b0;
      arr_disable <= cfg_disable;
      supv        <= FIELD_RST;
      dspace      <= FIELD_RST;
      protect     <= FIELD_RST;
      reg_done    <= 1'b0;
      reg_rdata   <= '0;
    end else begin
      reg_done  <= reg_req;
      reg_rdata <= rd ? rd_mux : '0;
      if (wr_ctrl) begin
        lock <= debug_mode ? reg_wdata[31] : (lock | reg_wdata[31]);
        if (!session_active) arr_disable <= reg_wdata[30];
        if (!lock) supv <= reg_wdata[8 +: FW];
      end
      if (wr_space && !lock) begin
        dspace  <= reg_wdata[0 +: FW];
        protect <= reg_wdata[8 +: FW];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      cnt        <= '0;
      arr_ack    <= 1'b0;
      arr_noresp <= 1'b0;
    end else begin
      arr_ack    <= 1'b0;
      arr_noresp <= 1'b0;
      if (busy) begin
        if (cnt == CW'(1)) begin
          busy       <= 1'b0;
          arr_noresp <= 1'b1;
        end
        cnt <= cnt - CW'(1);
      end else if (arr_req) begin
        if (arr_disable) begin
          busy <= 1'b1;
          cnt  <= CW'(TIMEOUT);
        end else begin
          arr_ack <= 1'b1;
        end
      end
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^reg_wdata[29:16];

  p_lock_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && !debug_mode) |=> lock);

  p_locked_fields_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> ($stable(supv) && $stable(dspace) && $stable(protect)));

  p_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req |=> reg_done);

  p_dis_session_r6: assert property (@(posedge clk) disable iff (!rst_n)
    session_active |=> $stable(arr_disable));

  p_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_req && !busy && !arr_disable) |=> arr_ack);

  p_no_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_req && !busy && arr_disable) |=> !arr_ack);

  p_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(arr_ack && arr_noresp));

  p_noresp_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    arr_noresp |-> !busy);

  p_enable_r10: assert property (@(posedge clk) arr_enable != arr_disable);
endmodule

// File: tb/test_flash_reg_lock.sv
module test_flash_reg_lock;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_disable = 1'b1;
  logic        debug_mode = 1'b0;
  logic        session_active = 1'b0;
  logic        reg_req = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        arr_req = 1'b0;
  logic [31:0] reg_rdata;
  logic        reg_done, arr_ack, arr_noresp, arr_enable, arr_disable, lock;
  logic [7:0]  supv, dspace, protect;

  flash_reg_lock i_flash_reg_lock (
    .clk, .rst_n, .cfg_disable, .debug_mode, .session_active,
    .reg_req, .reg_we, .reg_addr, .reg_wdata, .reg_rdata, .reg_done,
    .arr_req, .arr_ack, .arr_noresp, .arr_enable, .arr_disable,
    .lock, .supv, .dspace, .protect
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int tests = 0, fails = 0, cycles = 0;
  bit started = 0;

  // behavioural reference
  bit m_lock, m_dis, m_done, m_ack, m_noresp;
  bit [7:0] m_supv, m_data, m_prot;
  bit [31:0] m_rdata;
  int m_wait = 0;

  always @(posedge clk) begin
    bit old_lock, old_dis;
    old_lock = m_lock;
    old_dis  = m_dis;
    if (!rst_n) begin
      m_lock = 0; m_dis = cfg_disable; m_supv = 8'hFF; m_data = 8'hFF; m_prot = 8'hFF;
      m_done = 0; m_rdata = 0; m_ack = 0; m_noresp = 0; m_wait = 0;
      started = 1;
    end else begin
      m_done = reg_req;
      m_rdata = 0;
      if (reg_req && !reg_we) begin
        if (reg_addr == 4'h0) m_rdata = {m_lock, m_dis, 14'h0, m_supv, 8'h00};
        else if (reg_addr == 4'h4) m_rdata = {16'h0, m_prot, m_data};
      end
      if (reg_req && reg_we && reg_addr == 4'h0) begin
        if (!old_lock) m_supv = reg_wdata[15:8];
        if (debug_mode) m_lock = reg_wdata[31];
        else if (reg_wdata[31]) m_lock = 1;
        if (!session_active) m_dis = reg_wdata[30];
      end
      if (reg_req && reg_we && reg_addr == 4'h4 && !old_lock) begin
        m_data = reg_wdata[7:0];
        m_prot = reg_wdata[15:8];
      end
      m_ack = 0; m_noresp = 0;
      if (m_wait > 0) begin
        m_wait = m_wait - 1;
        if (m_wait == 0) m_noresp = 1;
      end else if (arr_req) begin
        if (old_dis) m_wait = 4;
        else m_ack = 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (started) begin
      check(lock == m_lock, "R2", "lock", 32'(lock), 32'(m_lock));
      check(supv == m_supv && dspace == m_data && protect == m_prot, "R4", "fields",
            {8'h0, supv, dspace, protect}, {8'h0, m_supv, m_data, m_prot});
      check(reg_done == m_done, "R4", "reg_done", 32'(reg_done), 32'(m_done));
      check(arr_disable == m_dis, "R6", "arr_disable", 32'(arr_disable), 32'(m_dis));
      check(reg_rdata == m_rdata, "R9", "reg_rdata", reg_rdata, m_rdata);
      check(arr_ack == m_ack, "R7", "arr_ack", 32'(arr_ack), 32'(m_ack));
      check(arr_noresp == m_noresp, "R8", "arr_noresp", 32'(arr_noresp), 32'(m_noresp));
      check(arr_enable == !m_dis, "R10", "arr_enable", 32'(arr_enable), 32'(!m_dis));
    end
    if (cycles > 5000) begin
      check(0, "watchdog", "timeout", 32'(cycles), 32'd5000);
      finish_run();
    end
  end

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_req = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_req = 0; reg_we = 0;
  endtask

  task automatic rd(input logic [3:0] a);
    @(negedge clk);
    reg_req = 1; reg_we = 0; reg_addr = a;
    @(negedge clk);
    reg_req = 0;
  endtask

  task automatic arr(input int gap);
    @(negedge clk);
    arr_req = 1;
    @(negedge clk);
    arr_req = 0;
    idle(gap);
  endtask

  task automatic do_reset(input bit pin);
    @(negedge clk);
    rst_n = 0; cfg_disable = pin;
    idle(2);
    rst_n = 1;
  endtask

  initial begin
    do_reset(1'b1);
    // R1: reset values, disable taken from pin
    check(lock == 0 && supv == 8'hFF && dspace == 8'hFF && protect == 8'hFF && arr_disable == 1,
          "R1", "reset state", {lock, arr_disable, 6'h0, supv, dspace, protect},
          {1'b1 == 0, 1'b1, 6'h0, 24'hFFFFFF});
    rd(4'h0); rd(4'h4);
    // R8: disabled array, request during wait ignored
    @(negedge clk); arr_req = 1; @(negedge clk); arr_req = 1; @(negedge clk); arr_req = 0;
    idle(6);
    // R6: disable write blocked during session
    session_active = 1;
    wr(4'h0, 32'h0000_FF00);
    session_active = 0;
    wr(4'h0, 32'h0000_FF00);
    // R7: enabled array access
    arr(2); arr(0); arr(3);
    // R5 and R9: unlocked field writes
    wr(4'h0, 32'h0000_A500);
    wr(4'h4, 32'h0000_3C5A);
    rd(4'h0); rd(4'h4); rd(4'h8);
    wr(4'h8, 32'hFFFF_FFFF);
    rd(4'h4);
    // R5: lock and field in one write
    wr(4'h0, 32'h8000_1200);
    check(supv == 8'h12 && lock == 1, "R5", "lock+supv same write",
          {23'h0, lock, supv}, {23'h0, 1'b1, 8'h12});
    // R4: locked writes ignored
    wr(4'h0, 32'h0000_7700);
    wr(4'h4, 32'h0000_1111);
    rd(4'h0); rd(4'h4);
    // R2: clearing lock ignored in normal mode; disable still writable
    wr(4'h0, 32'h4000_0000);
    arr(6);
    wr(4'h0, 32'h0000_0000);
    rd(4'h0);
    // R3: debug mode clears and sets lock
    debug_mode = 1;
    wr(4'h0, 32'h8000_5500);
    wr(4'h0, 32'h0000_6600);
    check(lock == 0, "R3", "debug clear", 32'(lock), 32'd0);
    wr(4'h0, 32'h0000_6600);
    check(supv == 8'h66, "R3", "debug unlocked write", 32'(supv), 32'h66);
    wr(4'h0, 32'h8000_0000);
    debug_mode = 0;
    rd(4'h0);
    // R1: second reset, pin low
    do_reset(1'b0);
    check(lock == 0 && arr_disable == 0 && protect == 8'hFF, "R1", "reset pin low",
          {lock, arr_disable, 22'h0, protect}, {2'b00, 22'h0, 8'hFF});
    arr(2);
    idle(2);
    finish_run();
  end
endmodule